// File: doc/BRIEF.md
# SD Command Path Engine

This block is the command side of an SD/MMC host controller. Software loads a 32-bit argument and then writes a 16-bit command word. The command word packs the opcode together with the expected response kind and the data-transfer flags, and the write itself starts the command. The engine serialises a 48-bit command frame on the CMD line and waits for the card's start bit within a bounded window. It then shifts in a 48-bit or 136-bit response and stores the payload in four readable 32-bit response words. The card clock is modelled as a one-cycle `sd_tick` strobe. Each tick moves one bit out on `cmd_out` or in from `cmd_in`. CRC computation lives elsewhere: the engine only latches a `crc_fail` flag that another block supplies.

The stop command (opcode 12, zero argument) has two paths that bypass the normal command register. Software can write a single stop bit to fire it at once. Software can also arm it so that it fires by itself when the data path reports the end of a multi-block transfer. The block also holds the block length, block count and bus-width settings, which the data path reads.

The controller states are IDLE, SEND, WAIT, RECV and DONE:
- IDLE→SEND is taken on a launch from the command register, the stop bit or the armed automatic stop.
- SEND→DONE is taken after the last frame bit when no response is expected.
- SEND→WAIT is taken after the last frame bit in every other case.
- WAIT→RECV is taken on a start bit.
- WAIT→DONE is taken when the window expires.
- RECV→DONE is taken after the last response bit.
- DONE→IDLE is always taken one cycle later.

Top module: `sd_cmd_engine`

## Requirements
- R1: Register map by word address: 0x0 argument, 0x1 command, 0x2 stop control, 0x3 block length, 0x4 block count, 0x5 bus option, 0x6 status, 0x8..0xB response words 0..3. Command word fields are: [5:0] opcode, [10:8] response type, bit 11 data present, bit 12 read, bit 13 multi-block. Bits 6 and 14 (application and security marks) are only stored. A launched command word reads back at 0x1.
- R2: A write to 0x1 while idle and with a valid type launches a command. The engine drives a 48-bit frame MSB first, one bit per `sd_tick`, with `cmd_oe` high. The frame is 0, 1, the opcode, the argument at 0x0, seven zero bits and a final 1. A command write while busy is ignored.
- R3: Response type codes 0, 1 and 2 are ignored: no frame is sent and busy stays low. Type 3 means no response: the command completes right after the frame.
- R4: Types 4, 5 and 7 take a 48-bit response. Word 0 receives frame bits 39:8 and words 1..3 read zero.
- R5: Type 6 takes a 136-bit response. The 8 header bits are dropped, and bits 127:0 fill words 3..0 with word 3 holding bits 127:96.
- R6: If `cmd_in` shows no 0 within 64 ticks after the last frame bit, the command ends with status bit 2 set. A start bit on the 64th tick is still accepted.
- R7: Status bit 0 (busy) is high from the cycle after a launch until completion. Bit 1 is set at every completion. Writing 1s to status clears bits 1..4.
- R8: Writing 1 to bit 0 of 0x2 while idle sends opcode 12 with argument 0 and expects a 48-bit response.
- R9: Bit 8 of 0x2, which reads back, arms an automatic opcode-12 command. A `data_done` pulse after a multi-block data command launches it. With bit 8 clear, `data_done` has no effect.
- R10: At 0x5, bit 15 set selects the 1-bit bus (`bus_4bit`=0) and bit 15 clear selects the 4-bit bus. The register reads back with low bits 0xE0 and resets to 0x80E0.
- R11: In 4-bit mode, a data command whose block length is below 4 is not launched and sets status bit 4.
- R12: `crc_fail` is sampled when a response ends and shows as status bit 3. It is not sampled on a timeout or when no response is expected.
- R13: At the completion of a data command without a timeout, `xfer_start` pulses for one cycle, with `xfer_read` and `xfer_multi` equal to bits 12 and 13. `blk_len` and `blk_cnt` follow 0x3 and 0x4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| sd_tick | input | 1 | Card clock strobe, one bit per pulse |
| cmd_in | input | 1 | Sampled CMD line from the card |
| cmd_out | output | 1 | CMD line value driven to the card |
| cmd_oe | output | 1 | CMD line output enable |
| crc_fail | input | 1 | Response CRC mismatch from the CRC checker |
| data_done | input | 1 | End-of-transfer pulse from the data path |
| xfer_start | output | 1 | Data phase may begin |
| xfer_read | output | 1 | Data phase direction is card to host |
| xfer_multi | output | 1 | Data phase spans several blocks |
| blk_len | output | 12 | Block length in bytes |
| blk_cnt | output | 16 | Number of blocks |
| bus_4bit | output | 1 | Four-bit data bus selected |

## Verification
The bench builds the engine with its default parameters: a 64-tick response window, 12-bit block length and 16-bit block count. The 64-tick window is short enough to drive both edges of the timeout rule directly: a start bit on the last tick, and a silent line for the full window. The random command sequence reaches every response kind, including full 136-bit responses. The directed cases cover both stop paths, rejection of a short block length in 4-bit mode, and a `data_done` pulse that should do nothing.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam logic [3:0] A_ARG    = 4'h0;
    localparam logic [3:0] A_CMD    = 4'h1;
    localparam logic [3:0] A_STOP   = 4'h2;
    localparam logic [3:0] A_BLKLEN = 4'h3;
    localparam logic [3:0] A_BLKCNT = 4'h4;
    localparam logic [3:0] A_BUSOPT = 4'h5;
    localparam logic [3:0] A_STATUS = 4'h6;

    localparam logic [2:0] RT_NONE = 3'd3;
    localparam logic [2:0] RT_R1   = 3'd4;
    localparam logic [2:0] RT_R1B  = 3'd5;
    localparam logic [2:0] RT_R2   = 3'd6;
    localparam logic [2:0] RT_R3   = 3'd7;

    localparam logic [5:0] OP_STOP = 6'd12;

    localparam int SHORT_BITS = 48;
    localparam int LONG_BITS  = 136;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RECV,
        ST_DONE
    } sdc_state_e;

    typedef struct packed {
        logic [5:0] op;
        logic [2:0] rtype;
        logic       data;
        logic       rd;
        logic       multi;
    } sdc_cmd_t;

    function automatic sdc_cmd_t decode_word(input logic [15:0] w);
        sdc_cmd_t d;
        d.op    = w[5:0];
        d.rtype = w[10:8];
        d.data  = w[11];
        d.rd    = w[12];
        d.multi = w[13];
        return d;
    endfunction

    function automatic logic [SHORT_BITS-1:0] build_frame(input logic [5:0] op,
                                                          input logic [31:0] a);
        return {1'b0, 1'b1, op, a, 7'd0, 1'b1};
    endfunction

endpackage

// File: rtl/sdc_regs.sv
module sdc_regs
    import sdc_pkg::*;
#(
    parameter int BLKLEN_W = 12,
    parameter int BLKCNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [3:0]          addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic                busy,
    input  logic [3:0][31:0]    resp_words,
    input  logic                ev_done,
    input  logic                ev_timeout,
    input  logic                ev_crc,
    output logic                go,
    output sdc_cmd_t            go_cmd,
    output logic [31:0]         arg,
    output logic                stop_req,
    output logic                auto_arm,
    output logic [BLKLEN_W-1:0] blk_len,
    output logic [BLKCNT_W-1:0] blk_cnt,
    output logic                bus_4bit
);

    localparam logic [BLKLEN_W-1:0] MIN_LEN_4BIT = BLKLEN_W'(4);
    localparam logic [15:0]         BUS_LOW_BITS = 16'h00E0;

    logic [31:0]         arg_q;
    logic [15:0]         cmd_word_q;
    logic                auto_arm_q;
    logic [BLKLEN_W-1:0] blk_len_q;
    logic [BLKCNT_W-1:0] blk_cnt_q;
    logic                bus_4bit_q;
    logic                rend_q;
    logic                to_q;
    logic                crc_q;
    logic                lenerr_q;

    sdc_cmd_t dec;
    logic     wr_cmd;
    logic     type_ok;
    logic     len_bad;

    always_comb begin
        dec      = decode_word(wdata[15:0]);
        wr_cmd   = wr_en && (addr == A_CMD);
        type_ok  = (dec.rtype >= RT_NONE);
        len_bad  = dec.data && bus_4bit_q && (blk_len_q < MIN_LEN_4BIT);
        go       = wr_cmd && type_ok && !len_bad && !busy;
        go_cmd   = dec;
        stop_req = wr_en && (addr == A_STOP) && wdata[0] && !busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arg_q      <= '0;
            cmd_word_q <= '0;
            auto_arm_q <= 1'b0;
            blk_len_q  <= '0;
            blk_cnt_q  <= '0;
            bus_4bit_q <= 1'b0;
            rend_q     <= 1'b0;
            to_q       <= 1'b0;
            crc_q      <= 1'b0;
            lenerr_q   <= 1'b0;
        end else begin
            if (wr_en) begin
                case (addr)
                    A_ARG:    arg_q      <= wdata;
                    A_STOP:   auto_arm_q <= wdata[8];
                    A_BLKLEN: blk_len_q  <= wdata[BLKLEN_W-1:0];
                    A_BLKCNT: blk_cnt_q  <= wdata[BLKCNT_W-1:0];
                    A_BUSOPT: bus_4bit_q <= !wdata[15];
                    A_STATUS: begin
                        if (wdata[1]) rend_q   <= 1'b0;
                        if (wdata[2]) to_q     <= 1'b0;
                        if (wdata[3]) crc_q    <= 1'b0;
                        if (wdata[4]) lenerr_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (go) cmd_word_q <= wdata[15:0];
            if (wr_cmd && type_ok && len_bad && !busy) lenerr_q <= 1'b1;
            if (ev_done)    rend_q <= 1'b1;
            if (ev_timeout) to_q   <= 1'b1;
            if (ev_crc)     crc_q  <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr[3]) begin
            rdata = resp_words[addr[1:0]];
        end else begin
            case (addr)
                A_ARG:    rdata = arg_q;
                A_CMD:    rdata = {16'd0, cmd_word_q};
                A_STOP:   rdata = {23'd0, auto_arm_q, 8'd0};
                A_BLKLEN: rdata = 32'(blk_len_q);
                A_BLKCNT: rdata = 32'(blk_cnt_q);
                A_BUSOPT: rdata = {16'd0, (BUS_LOW_BITS | {!bus_4bit_q, 15'd0})};
                A_STATUS: rdata = {27'd0, lenerr_q, crc_q, to_q, rend_q, busy};
                default:  rdata = '0;
            endcase
        end
    end

    assign arg      = arg_q;
    assign auto_arm = auto_arm_q;
    assign blk_len  = blk_len_q;
    assign blk_cnt  = blk_cnt_q;
    assign bus_4bit = bus_4bit_q;

    // R11: a short block in 4-bit mode must leave the error flag set
    assert_len_reject_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !busy && type_ok && dec.data && bus_4bit_q && (blk_len_q < MIN_LEN_4BIT))
        |=> lenerr_q);

    // R7: a completion event always leaves the completion flag set
    assert_done_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> rend_q);

endmodule

// File: rtl/sdc_cmd_fsm.sv
module sdc_cmd_fsm
    import sdc_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sd_tick,
    input  logic             cmd_in,
    input  logic             crc_fail,
    input  logic             go,
    input  sdc_cmd_t         go_cmd,
    input  logic [31:0]      arg,
    input  logic             stop_req,
    input  logic             auto_arm,
    input  logic             data_done,
    output logic             cmd_out,
    output logic             cmd_oe,
    output logic             busy,
    output logic [3:0][31:0] resp_words,
    output logic             ev_done,
    output logic             ev_timeout,
    output logic             ev_crc,
    output logic             xfer_start,
    output logic             xfer_read,
    output logic             xfer_multi
);

    localparam int WAIT_W = $clog2(TIMEOUT_TICKS + 1);
    localparam int CNT_W  = $clog2(LONG_BITS);
    localparam logic [WAIT_W-1:0] WAIT_LAST  = WAIT_W'(TIMEOUT_TICKS - 1);
    localparam logic [CNT_W-1:0]  TX_LAST    = CNT_W'(SHORT_BITS - 1);
    localparam logic [CNT_W-1:0]  RX_SHORT_N = CNT_W'(SHORT_BITS - 2);
    localparam logic [CNT_W-1:0]  RX_LONG_N  = CNT_W'(LONG_BITS - 2);

    sdc_state_e state, state_nxt;

    logic [SHORT_BITS-1:0] tx_sh;
    logic [CNT_W-1:0]      bit_cnt;
    logic [LONG_BITS-1:0]  rx_sh;
    logic [LONG_BITS-1:0]  rx_nxt;
    logic [WAIT_W-1:0]     wait_cnt;
    logic [3:0][31:0]      resp_q;
    sdc_cmd_t              cur;
    logic                  timed_out;
    logic                  got_rsp;
    logic                  multi_pend;

    logic auto_go;
    logic launch;
    logic wait_last;
    logic long_rsp;
    logic cnt_zero;

    always_comb begin
        auto_go   = data_done && auto_arm && multi_pend;
        launch    = go || stop_req || auto_go;
        wait_last = (wait_cnt == WAIT_LAST);
        long_rsp  = (cur.rtype == RT_R2);
        cnt_zero  = (bit_cnt == '0);
        rx_nxt    = {rx_sh[LONG_BITS-2:0], cmd_in};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (launch) state_nxt = ST_SEND;
            ST_SEND: if (sd_tick && cnt_zero)
                         state_nxt = (cur.rtype == RT_NONE) ? ST_DONE : ST_WAIT;
            ST_WAIT: if (sd_tick) begin
                         if (!cmd_in)        state_nxt = ST_RECV;
                         else if (wait_last) state_nxt = ST_DONE;
                     end
            ST_RECV: if (sd_tick && cnt_zero) state_nxt = ST_DONE;
            ST_DONE: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // shift registers, counters and captured response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh      <= '1;
            bit_cnt    <= '0;
            rx_sh      <= '0;
            wait_cnt   <= '0;
            resp_q     <= '0;
            cur        <= '0;
            timed_out  <= 1'b0;
            got_rsp    <= 1'b0;
            multi_pend <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (go) begin
                        cur        <= go_cmd;
                        tx_sh      <= build_frame(go_cmd.op, arg);
                        multi_pend <= go_cmd.data && go_cmd.multi;
                    end else if (stop_req || auto_go) begin
                        cur        <= '{op: OP_STOP, rtype: RT_R1B, data: 1'b0,
                                        rd: 1'b0, multi: 1'b0};
                        tx_sh      <= build_frame(OP_STOP, 32'd0);
                        multi_pend <= 1'b0;
                    end
                    if (launch) begin
                        bit_cnt   <= TX_LAST;
                        timed_out <= 1'b0;
                        got_rsp   <= 1'b0;
                    end
                end
                ST_SEND: begin
                    if (sd_tick) begin
                        tx_sh   <= {tx_sh[SHORT_BITS-2:0], 1'b1};
                        bit_cnt <= bit_cnt - 1'b1;
                        if (cnt_zero) begin
                            wait_cnt <= '0;
                            rx_sh    <= '0;
                        end
                    end
                end
                ST_WAIT: begin
                    if (sd_tick) begin
                        if (!cmd_in) begin
                            bit_cnt <= long_rsp ? RX_LONG_N : RX_SHORT_N;
                        end else begin
                            wait_cnt <= wait_cnt + 1'b1;
                            if (wait_last) timed_out <= 1'b1;
                        end
                    end
                end
                ST_RECV: begin
                    if (sd_tick) begin
                        rx_sh   <= rx_nxt;
                        bit_cnt <= bit_cnt - 1'b1;
                        if (cnt_zero) begin
                            got_rsp <= 1'b1;
                            if (long_rsp) resp_q <= rx_nxt[127:0];
                            else          resp_q <= {96'd0, rx_nxt[39:8]};
                        end
                    end
                end
                ST_DONE: begin
                    if (timed_out) multi_pend <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd_oe     = (state == ST_SEND);
        cmd_out    = (state == ST_SEND) ? tx_sh[SHORT_BITS-1] : 1'b1;
        busy       = (state != ST_IDLE);
        ev_done    = (state == ST_DONE);
        ev_timeout = ev_done && timed_out;
        ev_crc     = ev_done && got_rsp && crc_fail;
        xfer_start = ev_done && !timed_out && cur.data;
        xfer_read  = cur.rd;
        xfer_multi = cur.multi;
        resp_words = resp_q;
    end

    // R7: an accepted launch makes the engine busy in the next cycle
    assert_launch_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && launch) |=> busy);

    // R7: completion lasts exactly one cycle before returning to idle
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> !busy);

    // R6: the response window counter never exceeds its limit
    assert_wait_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (wait_cnt < WAIT_W'(TIMEOUT_TICKS)));

    // R8: a stop request loads opcode 12 with a zero argument
    assert_stop_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && !go && stop_req)
        |=> ((tx_sh[45:40] == OP_STOP) && (tx_sh[39:8] == 32'd0)));

    // R2: each frame begins with a zero start bit on the line
    assert_frame_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> (cmd_out == 1'b0));

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
    parameter int TIMEOUT_TICKS = 64,
    parameter int BLKLEN_W      = 12,
    parameter int BLKCNT_W      = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [3:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                sd_tick,
    input  logic                cmd_in,
    output logic                cmd_out,
    output logic                cmd_oe,
    input  logic                crc_fail,
    input  logic                data_done,
    output logic                xfer_start,
    output logic                xfer_read,
    output logic                xfer_multi,
    output logic [BLKLEN_W-1:0] blk_len,
    output logic [BLKCNT_W-1:0] blk_cnt,
    output logic                bus_4bit
);

    import sdc_pkg::*;

    logic             busy;
    logic [3:0][31:0] resp_words;
    logic             ev_done;
    logic             ev_timeout;
    logic             ev_crc;
    logic             go;
    sdc_cmd_t         go_cmd;
    logic [31:0]      arg;
    logic             stop_req;
    logic             auto_arm;

    sdc_regs #(
        .BLKLEN_W (BLKLEN_W),
        .BLKCNT_W (BLKCNT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .busy       (busy),
        .resp_words (resp_words),
        .ev_done    (ev_done),
        .ev_timeout (ev_timeout),
        .ev_crc     (ev_crc),
        .go         (go),
        .go_cmd     (go_cmd),
        .arg        (arg),
        .stop_req   (stop_req),
        .auto_arm   (auto_arm),
        .blk_len    (blk_len),
        .blk_cnt    (blk_cnt),
        .bus_4bit   (bus_4bit)
    );

    sdc_cmd_fsm #(
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sd_tick    (sd_tick),
        .cmd_in     (cmd_in),
        .crc_fail   (crc_fail),
        .go         (go),
        .go_cmd     (go_cmd),
        .arg        (arg),
        .stop_req   (stop_req),
        .auto_arm   (auto_arm),
        .data_done  (data_done),
        .cmd_out    (cmd_out),
        .cmd_oe     (cmd_oe),
        .busy       (busy),
        .resp_words (resp_words),
        .ev_done    (ev_done),
        .ev_timeout (ev_timeout),
        .ev_crc     (ev_crc),
        .xfer_start (xfer_start),
        .xfer_read  (xfer_read),
        .xfer_multi (xfer_multi)
    );

endmodule

// File: tb/tb_sd_cmd_engine.sv
module tb_sd_cmd_engine;

    localparam logic [3:0] T_ARG = 4'h0, T_CMD = 4'h1, T_STOP = 4'h2, T_BLKLEN = 4'h3,
                           T_BLKCNT = 4'h4, T_BUS = 4'h5, T_STS = 4'h6, T_RESP = 4'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sd_tick = 1'b0;
    logic        cmd_in = 1'b1;
    logic        cmd_out, cmd_oe;
    logic        crc_fail = 1'b0;
    logic        data_done = 1'b0;
    logic        xfer_start, xfer_read, xfer_multi;
    logic [11:0] blk_len;
    logic [15:0] blk_cnt;
    logic        bus_4bit;

    int checks = 0;
    int errors = 0;
    int xs_cnt = 0;
    logic xs_read = 1'b0, xs_multi = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sd_cmd_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sd_tick(sd_tick),
        .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .crc_fail(crc_fail),
        .data_done(data_done), .xfer_start(xfer_start), .xfer_read(xfer_read),
        .xfer_multi(xfer_multi), .blk_len(blk_len), .blk_cnt(blk_cnt), .bus_4bit(bus_4bit)
    );

    always @(negedge clk) begin
        if (xfer_start) begin
            xs_cnt++;
            xs_read  = xfer_read;
            xs_multi = xfer_multi;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [47:0] exp_frame(input logic [5:0] op, input logic [31:0] a);
        return {2'b01, op, a, 7'b0000000, 1'b1};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tick(input logic b, output logic o, output logic e);
        @(negedge clk);
        o = cmd_out; e = cmd_oe;
        cmd_in = b; sd_tick = 1'b1;
        @(negedge clk);
        sd_tick = 1'b0; cmd_in = 1'b1;
    endtask

    // capture the frame, feed the response and check status and response words
    task automatic complete(input string req, input logic [5:0] op, input logic [31:0] a,
                            input logic [2:0] rt, input bit to, input int dly, input bit crc);
        logic [47:0] f;
        logic [135:0] fr;
        logic o, e;
        bit oe_all;
        logic [31:0] v;
        int nb;
        oe_all = 1'b1;
        for (int i = 0; i < 48; i++) begin
            tick(1'b1, o, e);
            f = {f[46:0], o};
            oe_all = oe_all && e;
        end
        chk(req, "frame bits (R2)", f, exp_frame(op, a));
        chk("R2", "cmd_oe during frame", oe_all, 1'b1);
        if (rt == 3'd3) begin
            repeat (3) @(negedge clk);
            rd(T_STS, v);
            chk("R3", "status after no-response cmd", v, 32'h2);
        end else if (to) begin
            for (int i = 0; i < 64; i++) tick(1'b1, o, e);
            repeat (3) @(negedge clk);
            rd(T_STS, v);
            chk("R6", "status after timeout", v, 32'h6);
        end else begin
            nb = (rt == 3'd6) ? 136 : 48;
            for (int k = 0; k < 136; k++) fr[k] = 1'($urandom_range(0, 1));
            fr[nb-1] = 1'b0;
            crc_fail = crc;
            for (int i = 0; i < dly; i++) tick(1'b1, o, e);
            for (int i = nb - 1; i >= 0; i--) tick(fr[i], o, e);
            repeat (3) @(negedge clk);
            crc_fail = 1'b0;
            rd(T_STS, v);
            chk("R12", "status crc bit after response", v, crc ? 32'hA : 32'h2);
            if (nb == 136) begin
                for (int w = 0; w < 4; w++) begin
                    rd(T_RESP + 4'(w), v);
                    chk("R5", "long response word", v, fr[w*32 +: 32]);
                end
            end else begin
                rd(T_RESP, v);
                chk("R4", "short response word0", v, fr[39:8]);
                rd(T_RESP + 4'd3, v);
                chk("R4", "short response word3", v, 32'h0);
            end
        end
        wr(T_STS, 32'h1E);
    endtask

    task automatic do_cmd(input logic [15:0] word, input logic [31:0] a,
                          input bit to, input int dly, input bit crc);
        logic [31:0] v;
        int xs0;
        bit exp_x;
        wr(T_STS, 32'h1E);
        wr(T_ARG, a);
        xs0 = xs_cnt;
        wr(T_CMD, {16'h0, word});
        rd(T_STS, v);
        chk("R7", "busy after launch", v[0], 1'b1);
        complete("R2", word[5:0], a, word[10:8], to && (word[10:8] != 3'd3), dly, crc);
        rd(T_STS, v);
        chk("R7", "busy clear after completion", v[0], 1'b0);
        exp_x = word[11] && !(to && (word[10:8] != 3'd3));
        chk("R13", "xfer_start pulses", xs_cnt - xs0, exp_x ? 1 : 0);
        if (exp_x) begin
            chk("R13", "xfer_read", xs_read, word[12]);
            chk("R13", "xfer_multi", xs_multi, word[13]);
        end
        rd(T_CMD, v);
        chk("R1", "command word readback", v, {16'h0, word});
    endtask

    initial begin
        logic [31:0] v;
        logic [15:0] w;
        logic [2:0] rts [5];
        void'($urandom(32'd2024));
        rts[0] = 3'd3; rts[1] = 3'd4; rts[2] = 3'd5; rts[3] = 3'd6; rts[4] = 3'd7;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(T_STS, v);  chk("R7", "status after reset", v, 32'h0);
        rd(T_BUS, v);  chk("R10", "bus option after reset", v, 32'h80E0);
        chk("R10", "bus_4bit after reset", bus_4bit, 1'b0);
        rd(T_RESP, v); chk("R4", "response word0 after reset", v, 32'h0);
        chk("R2", "cmd_oe idle", cmd_oe, 1'b0);
        chk("R2", "cmd_out idle high", cmd_out, 1'b1);

        // directed: each response kind, app and security marks stored
        do_cmd(16'h0400 | 16'h0040 | 16'd17, 32'hDEADBEEF, 1'b0, 0, 1'b0);
        do_cmd(16'h0600 | 16'd2, 32'h0, 1'b0, 5, 1'b0);
        do_cmd(16'h0300 | 16'd0, 32'h12345678, 1'b0, 0, 1'b0);
        do_cmd(16'h0700 | 16'h4000 | 16'd41, 32'h00FF8000, 1'b0, 3, 1'b1);

        // timeout boundaries: start on the last allowed tick, then silence
        do_cmd(16'h0500 | 16'd7, 32'h00010000, 1'b0, 63, 1'b0);
        do_cmd(16'h0400 | 16'd13, 32'h0, 1'b1, 0, 1'b0);

        // invalid response type is ignored
        wr(T_CMD, 32'h0011);
        rd(T_STS, v);
        chk("R3", "invalid type not busy", v, 32'h0);
        chk("R3", "invalid type no drive", cmd_oe, 1'b0);

        // stop bit
        wr(T_STS, 32'h1E);
        wr(T_STOP, 32'h1);
        complete("R8", 6'd12, 32'h0, 3'd5, 1'b0, 2, 1'b0);
        rd(T_STOP, v); chk("R9", "stop register not armed", v, 32'h0);

        // no automatic stop when disarmed
        do_cmd(16'h3800 | 16'h0400 | 16'd18, 32'h100, 1'b0, 1, 1'b0);
        @(negedge clk); data_done = 1'b1; @(negedge clk); data_done = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9", "disarmed data_done no drive", cmd_oe, 1'b0);
        rd(T_STS, v); chk("R9", "disarmed data_done not busy", v, 32'h0);

        // automatic stop
        wr(T_STOP, 32'h100);
        rd(T_STOP, v); chk("R9", "arm bit readback", v, 32'h100);
        do_cmd(16'h3800 | 16'h0400 | 16'd18, 32'h200, 1'b0, 4, 1'b0);
        @(negedge clk); data_done = 1'b1; @(negedge clk); data_done = 1'b0;
        complete("R9", 6'd12, 32'h0, 3'd5, 1'b0, 0, 1'b0);
        wr(T_STOP, 32'h0);

        // block registers and bus width
        wr(T_BLKCNT, 32'd5);
        chk("R13", "blk_cnt output", blk_cnt, 16'd5);
        rd(T_BLKCNT, v); chk("R13", "blk_cnt readback", v, 32'd5);
        wr(T_BUS, 32'h0);
        chk("R10", "bus_4bit set", bus_4bit, 1'b1);
        rd(T_BUS, v); chk("R10", "4-bit readback", v, 32'h00E0);
        wr(T_BLKLEN, 32'd2);
        chk("R13", "blk_len output", blk_len, 12'd2);
        wr(T_STS, 32'h1E);
        wr(T_CMD, 32'h0C11);
        rd(T_STS, v); chk("R11", "short block rejected", v, 32'h10);
        chk("R11", "rejected no drive", cmd_oe, 1'b0);
        wr(T_BLKLEN, 32'd4);
        do_cmd(16'h1C00 | 16'd17, 32'h40, 1'b0, 2, 1'b0);
        wr(T_BUS, 32'h8000);
        rd(T_BUS, v); chk("R10", "1-bit readback", v, 32'h80E0);
        wr(T_BLKLEN, 32'd2);
        do_cmd(16'h0C00 | 16'd17, 32'h80, 1'b0, 1, 1'b0);

        // constrained random commands
        for (int n = 0; n < 16; n++) begin
            w = 16'($urandom_range(0, 63));
            w[10:8] = rts[$urandom_range(0, 4)];
            w[11] = 1'($urandom_range(0, 1));
            w[12] = 1'($urandom_range(0, 1));
            w[13] = 1'($urandom_range(0, 1));
            do_cmd(w, $urandom, ($urandom_range(0, 4) == 0), $urandom_range(0, 63),
                   1'($urandom_range(0, 1)));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule